// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a bus slave and decides, for every access, whether it may proceed. Software programs a small table of region descriptors. Each descriptor has an inclusive address window, a set of read, write and execute rights for each bus master, and an enable bit. Each access carries an address, a master number, an access kind and the index of the slave it targets. The checker compares the access against all enabled regions at the same time. Where regions overlap, their rights are ORed together. The access is allowed only if the combined rights include the requested kind for the requesting master.

A denied access gets an error response. The checker also logs the access into that slave's error-address and error-detail registers. A per-slave status bit then freezes that record until software clears the bit by writing 1 to it.

Descriptor updates are safe against a half-written region. Writing the start word, end word or rights word disables the region. Writing the control word enables it again. A separate alias word per region replaces only the rights and leaves the enable bit unchanged. This lets permissions change while the region stays live.

Top module: `mpc_top`

## Requirements
- R1: The register port is byte addressed. The four words of region r sit at r*16 + {0x0 start, 0x4 end, 0x8 rights, 0xC control}. Start reads back with its low 5 bits cleared. End reads back with its low 5 bits set. Control bit 0 is the enable.
- R2: An access matches an enabled region when start_block <= address_block <= end_block, where a block is 32 bytes. Both limits are inclusive.
- R3: In a rights word, master m has read at bit 3m, write at bit 3m+1 and execute at bit 3m+2. Access kind 0 is read, 1 is write and 2 is instruction fetch. Kind 3 is always denied.
- R4: An access that matches no enabled region is denied.
- R5: When an access matches several enabled regions, it is checked against the bitwise OR of their rights words.
- R6: A write to the start, end or rights word of a region clears its enable bit. A write to its control word loads the enable bit from bit 0 of the written data.
- R7: A write to the alias word at 0x80 + r*4 replaces the rights of region r and leaves its enable bit unchanged. The alias word reads back the rights. The first access after the write is checked with the new rights.
- R8: rsp_valid rises in the cycle after acc_valid, and rsp_err then shows whether that access was denied. Both outputs are low in the cycle after an idle cycle.
- R9: When a slave's status bit is clear, a denied access to that slave sets the bit. The same clock edge that produces the response also captures the address in the error-address register at 0xC0 + s*8 and the detail in the error-detail register at 0xC4 + s*8. Detail bits [1:0] hold the master, bits [5:4] the access kind, and bits [15:8] the mask of matched regions.
- R10: Status is read at 0xA0, with bit s for slave s. While a bit is set, further faults on that slave leave its error registers unchanged. Writing 1 to a status bit clears it, and writing 0 has no effect.
- R11: After reset every region is disabled, all status bits and error registers read 0, and no response is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| acc_valid | input | 1 | A bus access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_master | input | MID_W | Requesting master number |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| acc_slave | input | SLV_W | Index of the target slave port |
| rsp_valid | output | 1 | Check result is available |
| rsp_err | output | 1 | Access was denied |

## Verification
A stale or corrupted descriptor field shows up at the ports on the very next access: rsp_err flips one cycle after the access is presented, and the descriptor words read back the wrong values on the register port at once. A wrong enable bit after an address write makes a region grant or deny too early, which is visible on the first access after the write. A capture register that overwrites, or a status bit that does not clear, shows up as an error address or detail that differs from the first fault's values. This is visible when the register is read right after the second fault. Overlap errors appear as a grant that exactly one of two regions would refuse.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   // word index inside a 16-byte descriptor slot
   localparam logic [1:0] WORD_START  = 2'd0;
   localparam logic [1:0] WORD_END    = 2'd1;
   localparam logic [1:0] WORD_RIGHTS = 2'd2;
   localparam logic [1:0] WORD_CTRL   = 2'd3;

   // register map anchors
   localparam logic [7:0] STATUS_ADDR = 8'hA0;

   // error detail layout
   localparam int unsigned DET_KIND_LSB = 4;
   localparam int unsigned DET_HIT_LSB  = 8;

endpackage

// File: rtl/mpc_desc_store.sv
module mpc_desc_store #(
   parameter int unsigned N_REGIONS = 8,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BLK_LOG2  = 5,
   parameter int unsigned RGT_W     = 12,
   localparam int unsigned RIX_W    = $clog2(N_REGIONS),
   localparam int unsigned BLK_W    = ADDR_W - BLK_LOG2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_alias,
   input  logic [RIX_W-1:0]     wr_region,
   input  logic [1:0]           wr_word,
   input  logic [31:0]          wdata,
   output logic [BLK_W-1:0]     start_blk [N_REGIONS],
   output logic [BLK_W-1:0]     end_blk   [N_REGIONS],
   output logic [RGT_W-1:0]     rights    [N_REGIONS],
   output logic [N_REGIONS-1:0] valid
);
   import mpc_pkg::*;

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
      logic sel;
      logic en_q;
      assign sel = wr_en && (wr_region == RIX_W'(r));
      assign valid[r] = en_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_blk[r] <= '0;
            end_blk[r]   <= '0;
            rights[r]    <= '0;
            en_q         <= 1'b0;
         end else if (sel) begin
            if (wr_alias) begin
               rights[r] <= wdata[RGT_W-1:0];
            end else begin
               case (wr_word)
                  WORD_START: begin
                     start_blk[r] <= wdata[ADDR_W-1:BLK_LOG2];
                     en_q         <= 1'b0;
                  end
                  WORD_END: begin
                     end_blk[r] <= wdata[ADDR_W-1:BLK_LOG2];
                     en_q       <= 1'b0;
                  end
                  WORD_RIGHTS: begin
                     rights[r] <= wdata[RGT_W-1:0];
                     en_q      <= 1'b0;
                  end
                  default: en_q <= wdata[0];
               endcase
            end
         end
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

endmodule

// File: rtl/mpc_match.sv
module mpc_match #(
   parameter int unsigned N_REGIONS = 8,
   parameter int unsigned N_MASTERS = 4,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BLK_LOG2  = 5,
   localparam int unsigned MID_W    = $clog2(N_MASTERS),
   localparam int unsigned RGT_W    = 3 * N_MASTERS,
   localparam int unsigned BLK_W    = ADDR_W - BLK_LOG2
) (
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [MID_W-1:0]      acc_master,
   input  mpc_pkg::acc_kind_e    acc_kind,
   input  logic [BLK_W-1:0]      start_blk [N_REGIONS],
   input  logic [BLK_W-1:0]      end_blk   [N_REGIONS],
   input  logic [RGT_W-1:0]      rights    [N_REGIONS],
   input  logic [N_REGIONS-1:0]  valid,
   output logic [N_REGIONS-1:0]  hit,
   output logic                  grant
);
   import mpc_pkg::*;

   logic [BLK_W-1:0] blk;
   logic [RGT_W-1:0] merged;

   assign blk = acc_addr[ADDR_W-1:BLK_LOG2];

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_cmp
      assign hit[r] = valid[r] && (blk >= start_blk[r]) && (blk <= end_blk[r]);
   end

   always_comb begin
      merged = '0;
      for (int r = 0; r < N_REGIONS; r++) begin
         if (hit[r]) merged = merged | rights[r];
      end
   end

   always_comb begin
      grant = 1'b0;
      for (int m = 0; m < N_MASTERS; m++) begin
         if (acc_master == MID_W'(m)) begin
            case (acc_kind)
               ACC_READ:  grant = merged[3*m];
               ACC_WRITE: grant = merged[3*m+1];
               ACC_FETCH: grant = merged[3*m+2];
               default:   grant = 1'b0;
            endcase
         end
      end
   end

   logic unused_low;
   assign unused_low = ^acc_addr[BLK_LOG2-1:0];

endmodule

// File: rtl/mpc_err_log.sv
module mpc_err_log #(
   parameter int unsigned N_SLAVES = 2,
   parameter int unsigned ADDR_W   = 32,
   localparam int unsigned SLV_W   = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fault,
   input  logic [SLV_W-1:0]    fault_slave,
   input  logic [ADDR_W-1:0]   fault_addr,
   input  logic [31:0]         fault_detail,
   input  logic                clr_en,
   input  logic [N_SLAVES-1:0] clr_mask,
   output logic [N_SLAVES-1:0] status,
   output logic [ADDR_W-1:0]   err_addr   [N_SLAVES],
   output logic [31:0]         err_detail [N_SLAVES]
);

   for (genvar s = 0; s < N_SLAVES; s++) begin : g_slave
      logic held_q;
      logic take;
      logic [ADDR_W-1:0] addr_q;
      logic [31:0]       det_q;

      assign take          = fault && (fault_slave == SLV_W'(s)) && !held_q;
      assign status[s]     = held_q;
      assign err_addr[s]   = addr_q;
      assign err_detail[s] = det_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q <= 1'b0;
            addr_q <= '0;
            det_q  <= '0;
         end else if (take) begin
            held_q <= 1'b1;
            addr_q <= fault_addr;
            det_q  <= fault_detail;
         end else if (clr_en && clr_mask[s]) begin
            held_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mpc_top.sv
module mpc_top #(
   parameter int unsigned N_REGIONS = 8,
   parameter int unsigned N_MASTERS = 4,
   parameter int unsigned N_SLAVES  = 2,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BLK_LOG2  = 5,
   localparam int unsigned MID_W    = $clog2(N_MASTERS),
   localparam int unsigned SLV_W    = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [MID_W-1:0]  acc_master,
   input  logic [1:0]        acc_kind,
   input  logic [SLV_W-1:0]  acc_slave,
   output logic              rsp_valid,
   output logic              rsp_err
);
   import mpc_pkg::*;

   localparam int unsigned RIX_W = $clog2(N_REGIONS);
   localparam int unsigned RGT_W = 3 * N_MASTERS;
   localparam int unsigned BLK_W = ADDR_W - BLK_LOG2;

   if (N_REGIONS < 2 || N_REGIONS > 8) begin : g_bad_regions
      $error("mpc_top: N_REGIONS must be 2..8");
   end
   if (N_MASTERS < 2 || N_MASTERS > 8) begin : g_bad_masters
      $error("mpc_top: N_MASTERS must be 2..8");
   end
   if (N_SLAVES < 1 || N_SLAVES > 8) begin : g_bad_slaves
      $error("mpc_top: N_SLAVES must be 1..8");
   end
   if (ADDR_W > 32 || BLK_LOG2 < 2 || BLK_LOG2 >= ADDR_W) begin : g_bad_addr
      $error("mpc_top: address geometry out of range");
   end

   // register decode
   logic             desc_sel, alias_sel, err_sel, clr_en;
   logic [RIX_W-1:0] desc_idx, alias_idx;
   logic [1:0]       word;

   assign desc_sel  = !reg_addr[7] && (int'(reg_addr[6:4]) < N_REGIONS);
   assign alias_sel = (reg_addr[7:5] == 3'b100) && (int'(reg_addr[4:2]) < N_REGIONS);
   assign err_sel   = (reg_addr[7:6] == 2'b11) && (int'(reg_addr[5:3]) < N_SLAVES);
   assign desc_idx  = reg_addr[4 +: RIX_W];
   assign alias_idx = reg_addr[2 +: RIX_W];
   assign word      = reg_addr[3:2];
   assign clr_en    = reg_we && (reg_addr == STATUS_ADDR);

   logic [BLK_W-1:0]     d_start  [N_REGIONS];
   logic [BLK_W-1:0]     d_end    [N_REGIONS];
   logic [RGT_W-1:0]     d_rights [N_REGIONS];
   logic [N_REGIONS-1:0] desc_valid;

   mpc_desc_store #(
      .N_REGIONS(N_REGIONS), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .RGT_W(RGT_W)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we && (desc_sel || alias_sel)),
      .wr_alias  (alias_sel),
      .wr_region (alias_sel ? alias_idx : desc_idx),
      .wr_word   (word),
      .wdata     (reg_wdata),
      .start_blk (d_start),
      .end_blk   (d_end),
      .rights    (d_rights),
      .valid     (desc_valid)
   );

   // access check
   acc_kind_e            kind;
   logic [N_REGIONS-1:0] hit;
   logic                 grant;

   assign kind = acc_kind_e'(acc_kind);

   mpc_match #(
      .N_REGIONS(N_REGIONS), .N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)
   ) i_match (
      .acc_addr   (acc_addr),
      .acc_master (acc_master),
      .acc_kind   (kind),
      .start_blk  (d_start),
      .end_blk    (d_end),
      .rights     (d_rights),
      .valid      (desc_valid),
      .hit        (hit),
      .grant      (grant)
   );

   logic [31:0] detail;
   always_comb begin
      detail = '0;
      detail[MID_W-1:0]               = acc_master;
      detail[DET_KIND_LSB +: 2]       = acc_kind;
      detail[DET_HIT_LSB +: N_REGIONS] = hit;
   end

   logic [N_SLAVES-1:0] status;
   logic [ADDR_W-1:0]   e_addr [N_SLAVES];
   logic [31:0]         e_det  [N_SLAVES];

   mpc_err_log #(.N_SLAVES(N_SLAVES), .ADDR_W(ADDR_W)) i_log (
      .clk          (clk),
      .rst_n        (rst_n),
      .fault        (acc_valid && !grant),
      .fault_slave  (acc_slave),
      .fault_addr   (acc_addr),
      .fault_detail (detail),
      .clr_en       (clr_en),
      .clr_mask     (reg_wdata[N_SLAVES-1:0]),
      .status       (status),
      .err_addr     (e_addr),
      .err_detail   (e_det)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_err   <= acc_valid && !grant;
      end
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (desc_sel) begin
         case (word)
            WORD_START:  reg_rdata[ADDR_W-1:0] = {d_start[desc_idx], {BLK_LOG2{1'b0}}};
            WORD_END:    reg_rdata[ADDR_W-1:0] = {d_end[desc_idx], {BLK_LOG2{1'b1}}};
            WORD_RIGHTS: reg_rdata[RGT_W-1:0]  = d_rights[desc_idx];
            default:     reg_rdata[0]          = desc_valid[desc_idx];
         endcase
      end else if (alias_sel) begin
         reg_rdata[RGT_W-1:0] = d_rights[alias_idx];
      end else if (reg_addr == STATUS_ADDR) begin
         reg_rdata[N_SLAVES-1:0] = status;
      end else if (err_sel) begin
         if (reg_addr[2]) reg_rdata = e_det[reg_addr[3 +: SLV_W]];
         else             reg_rdata[ADDR_W-1:0] = e_addr[reg_addr[3 +: SLV_W]];
      end
   end

   logic unused_addr;
   assign unused_addr = ^reg_addr[1:0];

endmodule

// File: rtl/mpc_top_chk.sv
module mpc_top_chk #(
   parameter int unsigned N_REGIONS = 8,
   parameter int unsigned N_SLAVES  = 2,
   parameter int unsigned SLV_W     = 1,
   parameter int unsigned RIX_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_valid,
   input logic [SLV_W-1:0]     acc_slave,
   input logic [N_REGIONS-1:0] hit,
   input logic                 rsp_valid,
   input logic                 rsp_err,
   input logic [N_SLAVES-1:0]  status,
   input logic                 reg_we,
   input logic [7:0]           reg_addr,
   input logic [31:0]          reg_wdata,
   input logic [N_REGIONS-1:0] desc_valid
);

   assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

   assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!rsp_valid && !rsp_err));

   assert_nomatch_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (hit == '0)) |=> rsp_err);

   assert_fault_logged_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (hit == '0)) |=> status[$past(acc_slave)]);

   assert_addr_write_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_addr[7] && (reg_addr[3:2] != 2'd3) && (int'(reg_addr[6:4]) < N_REGIONS))
      |=> !desc_valid[$past(reg_addr[4 +: RIX_W])]);

   assert_alias_keeps_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (reg_addr[7:5] == 3'b100)) |=> $stable(desc_valid));

   for (genvar s = 0; s < N_SLAVES; s++) begin : g_sticky
      assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (status[s] && !(reg_we && (reg_addr == 8'hA0) && reg_wdata[s])) |=> status[s]);
   end

endmodule

bind mpc_top mpc_top_chk #(
   .N_REGIONS(N_REGIONS), .N_SLAVES(N_SLAVES), .SLV_W(SLV_W), .RIX_W(RIX_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_slave  (acc_slave),
   .hit        (hit),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err),
   .status     (status),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .desc_valid (desc_valid)
);

// File: tb/test_mpc_top.sv
module test_mpc_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_master = '0;
   logic [1:0]  acc_kind = '0;
   logic [0:0]  acc_slave = '0;
   logic        rsp_valid, rsp_err;

   int checks = 0;
   int failures = 0;
   bit exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mpc_top i_mpc_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_master(acc_master), .acc_kind(acc_kind),
      .acc_slave(acc_slave), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   // driver: presents one access and queues the expected verdict
   task automatic acc(logic [31:0] a, logic [1:0] m, logic [1:0] k, logic s,
                      bit exp_err, string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_master = m; acc_kind = k; acc_slave = s;
      exp_q.push_back(exp_err);
      tag_q.push_back(tag);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // monitor: compares each response with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check("R8 unexpected response", 32'(rsp_valid), 32'd0);
         end else begin
            string t;
            bit e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(rsp_err), 32'(e));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      check("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      rd(8'hA0, 32'h0, "R11 status after reset");
      rd(8'h0C, 32'h0, "R11 region0 disabled after reset");
      rd(8'hC0, 32'h0, "R11 error address after reset");
      acc(32'h0000_1000, 2'd0, 2'd0, 1'b0, 1'b1, "R4 R11 access with no regions");
      wr(8'hA0, 32'h3);

      // region 0: 0x1000..0x1FFF, master0 rwx, master1 read
      wr(8'h00, 32'h0000_1013);
      wr(8'h04, 32'h0000_1FE0);
      wr(8'h08, 32'h0000_000F);
      wr(8'h0C, 32'h1);
      rd(8'h00, 32'h0000_1000, "R1 start low bits cleared");
      rd(8'h04, 32'h0000_1FFF, "R1 end low bits set");
      rd(8'h08, 32'h0000_000F, "R1 rights readback");
      rd(8'h0C, 32'h1, "R1 R6 control enable");

      acc(32'h0000_1000, 2'd0, 2'd1, 1'b0, 1'b0, "R2 R3 master0 write at start");
      acc(32'h0000_1FFF, 2'd0, 2'd2, 1'b0, 1'b0, "R2 R3 master0 fetch at last byte");
      acc(32'h0000_1800, 2'd1, 2'd0, 1'b0, 1'b0, "R3 master1 read allowed");
      acc(32'h0000_1800, 2'd1, 2'd1, 1'b1, 1'b1, "R3 master1 write denied");
      rd(8'hC8, 32'h0000_1800, "R9 slave1 error address");
      rd(8'hCC, 32'h0000_0111, "R9 slave1 error detail");
      acc(32'h0000_2000, 2'd0, 2'd0, 1'b0, 1'b1, "R2 one past end denied");
      rd(8'hA0, 32'h3, "R9 both status bits set");
      rd(8'hC0, 32'h0000_2000, "R9 slave0 error address");
      rd(8'hC4, 32'h0000_0000, "R9 slave0 detail no hit");
      acc(32'h0000_0FE0, 2'd0, 2'd0, 1'b0, 1'b1, "R2 block below start denied");
      rd(8'hC0, 32'h0000_2000, "R10 slave0 record frozen");
      acc(32'h0000_1000, 2'd0, 2'd3, 1'b1, 1'b1, "R3 reserved kind denied");
      rd(8'hC8, 32'h0000_1800, "R10 slave1 record frozen");
      wr(8'hA0, 32'h1);
      rd(8'hA0, 32'h2, "R10 write-one clears only bit0");
      acc(32'h0000_0000, 2'd2, 2'd0, 1'b0, 1'b1, "R4 unmatched address denied");
      rd(8'hC0, 32'h0000_0000, "R10 slave0 recaptures after clear");
      rd(8'hC4, 32'h0000_0002, "R9 detail master2 read");
      wr(8'hA0, 32'h3);
      rd(8'hA0, 32'h0, "R10 all status cleared");

      // region 1: 0x1800..0x27FF, master1 write
      wr(8'h10, 32'h0000_1800);
      wr(8'h14, 32'h0000_27E0);
      wr(8'h18, 32'h0000_0010);
      wr(8'h1C, 32'h1);
      acc(32'h0000_1900, 2'd1, 2'd1, 1'b0, 1'b0, "R5 overlap grants write");
      acc(32'h0000_1900, 2'd1, 2'd0, 1'b0, 1'b0, "R5 overlap grants read");
      acc(32'h0000_2000, 2'd1, 2'd0, 1'b0, 1'b1, "R5 region1 alone denies read");
      rd(8'hC4, 32'h0000_0201, "R9 detail hit mask region1");
      wr(8'hA0, 32'h1);
      acc(32'h0000_1900, 2'd2, 2'd0, 1'b0, 1'b1, "R5 no rights for master2");
      rd(8'hC4, 32'h0000_0302, "R9 R5 detail both regions hit");
      wr(8'hA0, 32'h1);

      // R6 coherency of address writes
      wr(8'h00, 32'h0000_1000);
      rd(8'h0C, 32'h0, "R6 start write disables region");
      acc(32'h0000_1000, 2'd0, 2'd0, 1'b0, 1'b1, "R6 disabled region denies");
      wr(8'h0C, 32'h1);
      acc(32'h0000_1000, 2'd0, 2'd0, 1'b0, 1'b0, "R6 control write re-enables");
      wr(8'h08, 32'h0000_000F);
      rd(8'h0C, 32'h0, "R6 rights write disables region");
      wr(8'h0C, 32'h1);

      // R7 alias rights word
      wr(8'h80, 32'h0000_0009);
      rd(8'h0C, 32'h1, "R7 alias keeps enable");
      rd(8'h80, 32'h0000_0009, "R7 alias readback");
      acc(32'h0000_1000, 2'd0, 2'd1, 1'b0, 1'b1, "R7 new rights deny write");
      acc(32'h0000_1000, 2'd0, 2'd0, 1'b0, 1'b0, "R7 new rights keep read");

      // R6 clearing enable removes region
      wr(8'h0C, 32'h0);
      acc(32'h0000_1000, 2'd0, 2'd0, 1'b0, 1'b1, "R6 cleared enable denies");
      acc(32'h0000_1800, 2'd1, 2'd1, 1'b0, 1'b0, "R6 other region unaffected");

      repeat (2) @(negedge clk);
      check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
      summary();
      $finish;
   end
endmodule